// File: doc/BRIEF.md
# Carrier Tracking Loop Filter with Frequency-to-Phase Handover

This block is the arithmetic core of a carrier tracking channel. Once per integration period (nominally 1 ms) it receives the prompt in-phase and quadrature accumulations and a phase-error term. From these it produces a new carrier oscillator frequency word. A four-quadrant frequency discriminator differences the current sample against the previous one. It picks which difference to use, and with which sign, from the relative magnitudes and signs of I and Q.

The loop runs in three modes. It starts as a first-order frequency loop with a wide, fast gain. When the channel reports carrier lock it moves to the same loop with a narrow gain. When the frequency error becomes small it hands over to a second-order phase loop. Every loop gain is a power of two, so each multiply is an arithmetic right shift. The accumulators saturate instead of wrapping. A loss-of-lock input, or reset, returns the channel to its acquisition state.

Top module: `carr_loop_top`

## Requirements
- R1: After synchronous reset, `mode` is 0 (wide frequency loop), `freq_word` is 0, `upd_out` is 0, and the stored previous sample and the loop accumulator are 0.
- R2: On each update the frequency error uses dI = I − Iprev and dQ = Q − Qprev. If |I| > |Q| the error is +dQ when I > 0 and −dQ otherwise. If |I| ≤ |Q| the error is −dI when Q > 0 and +dI otherwise.
- R3: In mode 0 an update does acc ← sat(acc + e) and then freq_word ← sat(freq_word + (acc >>> SH_WIDE)), using the new acc value.
- R4: In mode 1 the update is the same as in R3 but uses the shift SH_NARROW.
- R5: An update in mode 0 with `carr_lock` high moves the block to mode 1. Mode 0 never goes straight to mode 2.
- R6: An update in mode 1 whose frequency error satisfies |e| < FE_LIM applies the mode-1 update, moves to mode 2 and clears acc. Mode 2 is left only through R9.
- R7: In mode 2 an update does acc ← sat(acc + p) with p = `ph_err`, then freq_word ← sat(freq_word + (acc >>> K1_SH) + (p >>> K2_SH)).
- R8: acc saturates at ±(2^(ACC_W−1)) bounds and freq_word saturates at the signed EST_W limits. Neither wraps.
- R9: `lock_lost` high at a clock edge forces mode 0 and clears freq_word, acc and the previous sample, overriding any update in the same cycle.
- R10: Without `upd_vld`, `freq_word` and `mode` hold their values whatever the other inputs do.
- R11: `upd_out` is high in the cycle after each accepted update and is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| upd_vld | input | 1 | One-cycle strobe: a new integration result is present |
| i_acc | input | IQ_W | Prompt in-phase accumulation, signed |
| q_acc | input | IQ_W | Prompt quadrature accumulation, signed |
| ph_err | input | PE_W | Phase-error term used in mode 2, signed |
| carr_lock | input | 1 | Carrier lock indication, sampled with upd_vld |
| lock_lost | input | 1 | Loss of lock: return to acquisition |
| freq_word | output | EST_W | Registered carrier frequency word, signed |
| mode | output | 2 | 0 wide frequency loop, 1 narrow frequency loop, 2 phase loop |
| upd_out | output | 1 | Pulses one cycle after each accepted update |

## Verification
The hardest condition to reach is accumulator saturation. The discriminator error is bounded by the sample range, so a steady input gives alternating differences that cancel. The bench therefore flips the signs of I and Q together on every update, which keeps the selected error positive at the same large value. With reduced widths this drives acc to its bound within a few updates and freq_word to its bound in about a hundred. The handover to mode 2 is reached by repeating a sample so that the differences are zero. A later loss of lock followed by a fresh update shows that acc and the previous sample were cleared.

// File: rtl/carr_loop_pkg.sv
package carr_loop_pkg;
  typedef enum logic [1:0] {
    MODE_WIDE   = 2'd0,
    MODE_NARROW = 2'd1,
    MODE_PLL    = 2'd2
  } cl_mode_e;
endpackage

// File: rtl/carr_fdisc.sv
// Four-quadrant frequency discriminator on consecutive samples.
module carr_fdisc #(
  parameter int IQ_W = 16,
  localparam int FE_W = IQ_W + 2
) (
  input  logic signed [IQ_W-1:0] i_cur,
  input  logic signed [IQ_W-1:0] q_cur,
  input  logic signed [IQ_W-1:0] i_prv,
  input  logic signed [IQ_W-1:0] q_prv,
  output logic signed [FE_W-1:0] err
);
  logic signed [IQ_W:0] ie, qe, di, dq, ai, aq;

  always_comb begin
    ie  = {i_cur[IQ_W-1], i_cur};
    qe  = {q_cur[IQ_W-1], q_cur};
    di  = ie - {i_prv[IQ_W-1], i_prv};
    dq  = qe - {q_prv[IQ_W-1], q_prv};
    ai  = i_cur[IQ_W-1] ? -ie : ie;
    aq  = q_cur[IQ_W-1] ? -qe : qe;
    if ($unsigned(ai) > $unsigned(aq)) begin
      if (!i_cur[IQ_W-1] && (i_cur != '0)) err = {dq[IQ_W], dq};
      else                                 err = -{dq[IQ_W], dq};
    end else begin
      if (!q_cur[IQ_W-1] && (q_cur != '0)) err = -{di[IQ_W], di};
      else                                 err = {di[IQ_W], di};
    end
  end
endmodule

// File: rtl/carr_mode_fsm.sv
// Mode sequencing: wide FLL -> narrow FLL -> PLL, back to wide on loss.
module carr_mode_fsm
  import carr_loop_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     lock_lost,
  input  logic     upd,
  input  logic     carr_lock,
  input  logic     fe_small,
  output cl_mode_e mode_q,
  output logic     to_pll
);
  cl_mode_e nxt;

  always_comb begin
    nxt    = mode_q;
    to_pll = 1'b0;
    if (upd) begin
      case (mode_q)
        MODE_WIDE:   if (carr_lock) nxt = MODE_NARROW;
        MODE_NARROW: if (fe_small) begin
          nxt    = MODE_PLL;
          to_pll = 1'b1;
        end
        default: nxt = mode_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst || lock_lost) mode_q <= MODE_WIDE;
    else                  mode_q <= nxt;
  end
endmodule

// File: rtl/carr_loop_filt.sv
// Shift-only loop filter with saturating accumulator and estimate.
module carr_loop_filt
  import carr_loop_pkg::*;
#(
  parameter int IQ_W      = 16,
  parameter int PE_W      = 16,
  parameter int ACC_W     = 24,
  parameter int EST_W     = 32,
  parameter int SH_WIDE   = 3,
  parameter int SH_NARROW = 8,
  parameter int K1_SH     = 10,
  parameter int K2_SH     = 4,
  localparam int FE_W     = IQ_W + 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clr,
  input  logic                    upd,
  input  cl_mode_e                mode,
  input  logic                    to_pll,
  input  logic signed [FE_W-1:0]  fe,
  input  logic signed [PE_W-1:0]  pe,
  output logic signed [EST_W-1:0] est_q
);
  localparam int SW = ACC_W + 2;
  localparam int ET = EST_W + 2;
  localparam logic signed [SW-1:0] A_MAX = {3'b000, {(ACC_W-1){1'b1}}};
  localparam logic signed [SW-1:0] A_MIN = {3'b111, {(ACC_W-1){1'b0}}};
  localparam logic signed [ET-1:0] E_MAX = {3'b000, {(EST_W-1){1'b1}}};
  localparam logic signed [ET-1:0] E_MIN = {3'b111, {(EST_W-1){1'b0}}};

  logic signed [ACC_W-1:0] acc_q, acc_new, acc_shf;
  logic signed [SW-1:0]    e_ext, a_sum;
  logic signed [PE_W-1:0]  p_shf;
  logic signed [ET-1:0]    inc_a, inc_p, e_sum;
  logic signed [EST_W-1:0] est_new;
  logic [5:0]              sh;
  logic                    is_pll;

  always_comb begin
    is_pll = (mode == MODE_PLL);
    if (is_pll) e_ext = {{(SW-PE_W){pe[PE_W-1]}}, pe};
    else        e_ext = {{(SW-FE_W){fe[FE_W-1]}}, fe};
    a_sum = {{2{acc_q[ACC_W-1]}}, acc_q} + e_ext;
    if (a_sum > A_MAX)      acc_new = A_MAX[ACC_W-1:0];
    else if (a_sum < A_MIN) acc_new = A_MIN[ACC_W-1:0];
    else                    acc_new = a_sum[ACC_W-1:0];

    case (mode)
      MODE_WIDE:   sh = 6'(SH_WIDE);
      MODE_NARROW: sh = 6'(SH_NARROW);
      default:     sh = 6'(K1_SH);
    endcase
    acc_shf = acc_new >>> sh;
    p_shf   = pe >>> K2_SH;
    inc_a   = {{(ET-ACC_W){acc_shf[ACC_W-1]}}, acc_shf};
    inc_p   = is_pll ? {{(ET-PE_W){p_shf[PE_W-1]}}, p_shf} : '0;
    e_sum   = {{2{est_q[EST_W-1]}}, est_q} + inc_a + inc_p;
    if (e_sum > E_MAX)      est_new = E_MAX[EST_W-1:0];
    else if (e_sum < E_MIN) est_new = E_MIN[EST_W-1:0];
    else                    est_new = e_sum[EST_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      acc_q <= '0;
      est_q <= '0;
    end else if (upd) begin
      acc_q <= to_pll ? '0 : acc_new;
      est_q <= est_new;
    end
  end
endmodule

// File: rtl/carr_loop_top.sv
module carr_loop_top
  import carr_loop_pkg::*;
#(
  parameter int IQ_W      = 16,
  parameter int PE_W      = 16,
  parameter int ACC_W     = 24,
  parameter int EST_W     = 32,
  parameter int SH_WIDE   = 3,
  parameter int SH_NARROW = 8,
  parameter int K1_SH     = 10,
  parameter int K2_SH     = 4,
  parameter int FE_LIM    = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             upd_vld,
  input  logic [IQ_W-1:0]  i_acc,
  input  logic [IQ_W-1:0]  q_acc,
  input  logic [PE_W-1:0]  ph_err,
  input  logic             carr_lock,
  input  logic             lock_lost,
  output logic [EST_W-1:0] freq_word,
  output logic [1:0]       mode,
  output logic             upd_out
);
  localparam int FE_W = IQ_W + 2;
  localparam logic [FE_W-1:0] LIM = FE_W'(FE_LIM);

  logic signed [IQ_W-1:0]  i_prv, q_prv;
  logic signed [FE_W-1:0]  fe, fe_abs;
  logic signed [EST_W-1:0] est;
  logic                    fe_small, to_pll;
  cl_mode_e                mode_q;

  carr_fdisc #(.IQ_W(IQ_W)) u_disc (
    .i_cur(i_acc), .q_cur(q_acc), .i_prv(i_prv), .q_prv(q_prv), .err(fe)
  );

  always_comb begin
    fe_abs   = fe[FE_W-1] ? -fe : fe;
    fe_small = ($unsigned(fe_abs) < LIM);
  end

  carr_mode_fsm u_fsm (
    .clk(clk), .rst(rst), .lock_lost(lock_lost), .upd(upd_vld),
    .carr_lock(carr_lock), .fe_small(fe_small), .mode_q(mode_q), .to_pll(to_pll)
  );

  carr_loop_filt #(
    .IQ_W(IQ_W), .PE_W(PE_W), .ACC_W(ACC_W), .EST_W(EST_W),
    .SH_WIDE(SH_WIDE), .SH_NARROW(SH_NARROW), .K1_SH(K1_SH), .K2_SH(K2_SH)
  ) u_filt (
    .clk(clk), .rst(rst), .clr(lock_lost), .upd(upd_vld), .mode(mode_q),
    .to_pll(to_pll), .fe(fe), .pe(ph_err), .est_q(est)
  );

  always_ff @(posedge clk) begin
    if (rst || lock_lost) begin
      i_prv   <= '0;
      q_prv   <= '0;
      upd_out <= 1'b0;
    end else begin
      upd_out <= upd_vld;
      if (upd_vld) begin
        i_prv <= i_acc;
        q_prv <= q_acc;
      end
    end
  end

  assign freq_word = est;
  assign mode      = mode_q;
endmodule

// File: rtl/carr_loop_chk.sv
module carr_loop_chk #(
  parameter int EST_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             upd_vld,
  input logic             lock_lost,
  input logic [EST_W-1:0] freq_word,
  input logic [1:0]       mode,
  input logic             upd_out
);
  // R9
  lost_clears_chk: assert property (@(posedge clk) disable iff (rst)
    lock_lost |=> (mode == 2'd0 && freq_word == '0));
  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!upd_vld && !lock_lost) |=> ($stable(freq_word) && $stable(mode)));
  // R11
  upd_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (upd_vld && !lock_lost) |=> upd_out);
  // R11
  no_spurious_chk: assert property (@(posedge clk) disable iff (rst)
    !upd_vld |=> !upd_out);
  // R5
  mode_order_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'd0 && !lock_lost) |=> (mode != 2'd2));
  // R6
  pll_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'd2 && !lock_lost) |=> (mode == 2'd2));
  // R6
  mode_legal_chk: assert property (@(posedge clk) disable iff (rst)
    mode != 2'd3);
endmodule

bind carr_loop_top carr_loop_chk #(.EST_W(EST_W)) u_chk (
  .clk(clk), .rst(rst), .upd_vld(upd_vld), .lock_lost(lock_lost),
  .freq_word(freq_word), .mode(mode), .upd_out(upd_out)
);

// File: tb/sim_carr_loop_top.sv
`timescale 1ns/1ps
module sim_carr_loop_top;
  localparam int IW = 12, PW = 12, AW = 16, EW = 20;
  localparam int SHW = 3, SHN = 8, K1 = 10, K2 = 4, LIM = 16;
  localparam longint A_MAX = (longint'(1) <<< (AW-1)) - 1;
  localparam longint A_MIN = -(longint'(1) <<< (AW-1));
  localparam longint E_MAX = (longint'(1) <<< (EW-1)) - 1;
  localparam longint E_MIN = -(longint'(1) <<< (EW-1));

  logic clk = 1'b0, rst = 1'b1, upd_vld = 1'b0, carr_lock = 1'b0, lock_lost = 1'b0;
  logic [IW-1:0] i_acc = '0, q_acc = '0;
  logic [PW-1:0] ph_err = '0;
  logic [EW-1:0] freq_word;
  logic [1:0]    mode;
  logic          upd_out;

  int nchk = 0, nerr = 0;
  bit done = 0;
  longint m_mode, m_acc, m_est, m_pi, m_pq;

  always #2.5 clk = ~clk;

  carr_loop_top #(
    .IQ_W(IW), .PE_W(PW), .ACC_W(AW), .EST_W(EW), .SH_WIDE(SHW),
    .SH_NARROW(SHN), .K1_SH(K1), .K2_SH(K2), .FE_LIM(LIM)
  ) u0 (
    .clk(clk), .rst(rst), .upd_vld(upd_vld), .i_acc(i_acc), .q_acc(q_acc),
    .ph_err(ph_err), .carr_lock(carr_lock), .lock_lost(lock_lost),
    .freq_word(freq_word), .mode(mode), .upd_out(upd_out)
  );

  function automatic longint clamp(longint v, longint lo, longint hi);
    return (v > hi) ? hi : ((v < lo) ? lo : v);
  endfunction

  task automatic chk(string req, string what, longint act, longint exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic void model_clear();
    m_mode = 0; m_acc = 0; m_est = 0; m_pi = 0; m_pq = 0;
  endfunction

  function automatic void model_step(longint I, longint Q, longint P, bit lk);
    longint di, dq, e, s, inc;
    di = I - m_pi; dq = Q - m_pq;
    if ((I < 0 ? -I : I) > (Q < 0 ? -Q : Q)) e = (I > 0) ? dq : -dq;
    else                                     e = (Q > 0) ? -di : di;
    if (m_mode == 2) begin
      s = clamp(m_acc + P, A_MIN, A_MAX);
      inc = (s >>> K1) + (P >>> K2);
    end else begin
      s = clamp(m_acc + e, A_MIN, A_MAX);
      inc = s >>> ((m_mode == 0) ? SHW : SHN);
    end
    m_acc = s;
    m_est = clamp(m_est + inc, E_MIN, E_MAX);
    if (m_mode == 0 && lk) m_mode = 1;
    else if (m_mode == 1 && (e < 0 ? -e : e) < LIM) begin
      m_mode = 2; m_acc = 0;
    end
    m_pi = I; m_pq = Q;
  endfunction

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
    model_clear();
  endtask

  task automatic apply(longint I, longint Q, longint P, bit lk, string req);
    @(negedge clk);
    i_acc = I[IW-1:0]; q_acc = Q[IW-1:0]; ph_err = P[PW-1:0];
    carr_lock = lk; upd_vld = 1'b1;
    model_step(I, Q, P, lk);
    @(negedge clk);
    upd_vld = 1'b0; carr_lock = 1'b0;
    chk(req, "freq_word", longint'($signed(freq_word)), m_est);
    chk(req, "mode", longint'(mode), m_mode);
    chk("R11", "upd_out", longint'(upd_out), 1);
  endtask

  task automatic t_reset();  // R1
    do_reset();
    chk("R1", "mode", longint'(mode), 0);
    chk("R1", "freq_word", longint'($signed(freq_word)), 0);
    chk("R1", "upd_out", longint'(upd_out), 0);
  endtask

  task automatic t_disc();  // R2: four quadrants and the |I|==|Q| tie
    do_reset(); apply(400, 30, 0, 0, "R2");   // I major, I>0: +dQ
    do_reset(); apply(-400, 30, 0, 0, "R2");  // I major, I<0: -dQ
    do_reset(); apply(30, 400, 0, 0, "R2");   // Q major, Q>0: -dI
    do_reset(); apply(30, -400, 0, 0, "R2");  // Q major, Q<0: +dI
    do_reset(); apply(200, -200, 0, 0, "R2"); // tie takes Q branch
    apply(-300, 250, 0, 0, "R2");
    apply(100, 600, 0, 0, "R2");
  endtask

  task automatic t_idle();  // R10, R11
    longint fw;
    fw = longint'($signed(freq_word));
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      i_acc = IW'(k * 321); q_acc = IW'(k * 77); ph_err = PW'(k * 9); carr_lock = 1'b1;
    end
    @(negedge clk); carr_lock = 1'b0;
    chk("R10", "freq_word held", longint'($signed(freq_word)), fw);
    chk("R10", "mode held", longint'(mode), m_mode);
    chk("R11", "upd_out idle", longint'(upd_out), 0);
  endtask

  task automatic t_sequence();  // R3, R4, R5, R6, R7
    do_reset();
    for (int k = 0; k < 4; k++)
      apply((k % 2) ? -1500 : 1500, (k % 2) ? -900 : 900, 0, 0, "R3");
    chk("R3", "still wide", longint'(mode), 0);
    apply(1500, 900, 0, 1, "R5");
    chk("R5", "narrow entered", longint'(mode), 1);
    for (int k = 0; k < 4; k++)
      apply((k % 2) ? 1500 : -1500, (k % 2) ? 900 : -900, 0, 0, "R4");
    chk("R4", "still narrow", longint'(mode), 1);
    apply(1500, 900, 0, 0, "R4");
    apply(1500, 900, 0, 0, "R6");
    chk("R6", "phase loop entered", longint'(mode), 2);
    apply(10, 10, 700, 0, "R7");
    apply(10, 10, -300, 0, "R7");
    apply(-900, 5, 2000, 1, "R7");
    chk("R6", "phase loop held", longint'(mode), 2);
  endtask

  task automatic t_lost();  // R9
    @(negedge clk); lock_lost = 1'b1; upd_vld = 1'b1;
    i_acc = IW'(55); q_acc = IW'(66);
    @(negedge clk); lock_lost = 1'b0; upd_vld = 1'b0;
    model_clear();
    chk("R9", "mode", longint'(mode), 0);
    chk("R9", "freq_word", longint'($signed(freq_word)), 0);
    chk("R9", "upd_out", longint'(upd_out), 0);
    apply(800, 100, 0, 0, "R9");
    apply(800, 40, 0, 0, "R9");
  endtask

  task automatic t_sat();  // R8
    do_reset();
    for (int k = 0; k < 170; k++)
      apply((k % 2) ? -2047 : 2047, (k % 2) ? -2040 : 2040, 0, 0, "R8");
    chk("R8", "freq_word at max", longint'($signed(freq_word)), E_MAX);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
      $finish;
    end
  end

  initial begin
    model_clear();
    t_reset();
    t_disc();
    t_idle();
    t_sequence();
    t_idle();
    t_lost();
    t_sat();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end
endmodule